// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps the interrupt state of a set of external request lines. Each line has three state bits: enable, pending and active. One mechanism serves every line, and there is no per-line setting for level or pulse requests. A request line that is held high and a line that is pulsed for a single cycle both leave the line pending. Once the handler for a line is running, only a new rising edge pends the line again. When the handler returns, the line is sampled again, so a level that is still held re-pends the line even without a new edge.

Software reaches the state through one write port. The port carries an operation code and a data word. Four operations are write-one-to-act bit masks: set enable, clear enable, set pending and clear pending. The fifth takes a line number and pends that line. The core reports two events, each with a line number: entering a handler and returning from one. The outputs are the enable, pending and active vectors, and a candidate vector. A line is a candidate when it is pending and enabled and no handler for it is running.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset, the enable, pending, active and candidate vectors are all zero and the any-candidate flag is low.
- R2: A request line that is high at a clock edge, while its handler is not running, leaves its pending bit set after that edge. This holds for a level held over many cycles and for a pulse one cycle long.
- R3: An enter event for line k sets active bit k and clears pending bit k at the same edge. The exception is a rising edge on request k in that same cycle, which keeps the bit pending.
- R4: While line k is active, a request that stays high does not re-pend it. A low-to-high transition on request k sets pending bit k again.
- R5: A return event for line k clears active bit k. If request k is high in that cycle, pending bit k is set at the same edge, even with no new edge on the request.
- R6: Enable bits are independent of pending bits. A disabled line still becomes pending and stays pending, and it becomes a candidate as soon as it is enabled. The enable vector changes only through writes.
- R7: On a write (wr_valid_i high), op code 0 sets and op code 1 clears the enable bits marked by ones in wr_data_i. Op code 2 sets and op code 3 clears the pending bits marked by ones. Zero bits in the data have no effect.
- R8: Op code 4 treats wr_data_i as an unsigned line number and pends that line, with the same result as a hardware request. A number not below NUM_LINES changes nothing. Op codes 5 to 7 do nothing.
- R9: A clear-pending write leaves a line pending if, in the same cycle, its request is high while the line is inactive, or its request rises.
- R10: cand_o equals pend_o AND en_o AND NOT act_o, bit by bit. cand_any_o is high exactly when cand_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LINES | Request lines, synchronous to clk_i |
| wr_valid_i | input | 1 | Write strobe |
| wr_op_i | input | 3 | Write operation code (see R7, R8) |
| wr_data_i | input | NUM_LINES | Bit mask, or a line number for op code 4 |
| enter_i | input | 1 | Core enters a handler |
| enter_id_i | input | ID_W | Line whose handler is entered |
| ret_i | input | 1 | Core returns from a handler |
| ret_id_i | input | ID_W | Line whose handler returns |
| en_o | output | NUM_LINES | Enable vector |
| pend_o | output | NUM_LINES | Pending vector |
| act_o | output | NUM_LINES | Active vector |
| cand_o | output | NUM_LINES | Pending, enabled and not active |
| cand_any_o | output | 1 | Some line is a candidate |

## Verification
The hardest cases to reach are collisions inside a single cycle. One is a return while the request is still held high. The other is a clear-pending write that lands in the same cycle as a rising request edge on a line that is already pending. The stimulus reaches the second case by pending the line through software with its request low, then driving the clear write and the rising request at the same falling clock edge. The re-pend while active is reached by entering the handler of a pulsed line and pulsing that line again before the return.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic [2:0] {
    OP_SET_EN   = 3'd0,
    OP_CLR_EN   = 3'd1,
    OP_SET_PEND = 3'd2,
    OP_CLR_PEND = 3'd3,
    OP_TRIG     = 3'd4
  } wr_op_e;

  function automatic int unsigned id_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_onehot_dec.sv
module irq_onehot_dec #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_OUT-1:0] vec_o
);
  // out-of-range index yields an all-zero vector
  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      vec_o[i] = en_i && (32'(idx_i) == i);
    end
  end
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_trk_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 wr_valid_i,
  input  logic [2:0]           wr_op_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  output logic [NUM_LINES-1:0] en_set_o,
  output logic [NUM_LINES-1:0] en_clr_o,
  output logic [NUM_LINES-1:0] pend_set_o,
  output logic [NUM_LINES-1:0] pend_clr_o
);
  logic                 trig_en;
  logic [NUM_LINES-1:0] trig_vec;

  assign trig_en = wr_valid_i && (wr_op_i == OP_TRIG);

  irq_onehot_dec #(
    .NUM_OUT(NUM_LINES),
    .IDX_W  (NUM_LINES)
  ) u_trig_dec (
    .en_i (trig_en),
    .idx_i(wr_data_i),
    .vec_o(trig_vec)
  );

  always_comb begin
    en_set_o   = '0;
    en_clr_o   = '0;
    pend_set_o = trig_vec;
    pend_clr_o = '0;
    if (wr_valid_i) begin
      unique case (wr_op_i)
        OP_SET_EN:   en_set_o   = wr_data_i;
        OP_CLR_EN:   en_clr_o   = wr_data_i;
        OP_SET_PEND: pend_set_o = wr_data_i;
        OP_CLR_PEND: pend_clr_o = wr_data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic enter_i,
  input  logic ret_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic pend_set_i,
  input  logic pend_clr_i,
  output logic en_o,
  output logic pend_o,
  output logic act_o
);
  logic req_q, rise, hw_set;
  logic en_q, pend_q, act_q;

  assign rise = req_i & ~req_q;

  // once a handler is running (or starting), only an edge or a return sample re-pends
  always_comb begin
    if (act_q || enter_i) hw_set = rise | (ret_i & req_i);
    else                  hw_set = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      req_q  <= req_i;
      en_q   <= (en_q | en_set_i) & ~en_clr_i;
      pend_q <= (pend_q & ~pend_clr_i & ~enter_i) | hw_set | pend_set_i;
      act_q  <= (act_q & ~ret_i) | enter_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irq_trk_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned ID_W     = id_width(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 wr_valid_i,
  input  logic [2:0]           wr_op_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  input  logic                 enter_i,
  input  logic [ID_W-1:0]      enter_id_i,
  input  logic                 ret_i,
  input  logic [ID_W-1:0]      ret_id_i,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] act_o,
  output logic [NUM_LINES-1:0] cand_o,
  output logic                 cand_any_o
);
  logic [NUM_LINES-1:0] en_set, en_clr, pend_set, pend_clr;
  logic [NUM_LINES-1:0] enter_vec, ret_vec;

  irq_wr_decode #(.NUM_LINES(NUM_LINES)) u_wr_dec (
    .wr_valid_i(wr_valid_i),
    .wr_op_i   (wr_op_i),
    .wr_data_i (wr_data_i),
    .en_set_o  (en_set),
    .en_clr_o  (en_clr),
    .pend_set_o(pend_set),
    .pend_clr_o(pend_clr)
  );

  irq_onehot_dec #(.NUM_OUT(NUM_LINES), .IDX_W(ID_W)) u_enter_dec (
    .en_i (enter_i),
    .idx_i(enter_id_i),
    .vec_o(enter_vec)
  );

  irq_onehot_dec #(.NUM_OUT(NUM_LINES), .IDX_W(ID_W)) u_ret_dec (
    .en_i (ret_i),
    .idx_i(ret_id_i),
    .vec_o(ret_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[g]),
      .enter_i   (enter_vec[g]),
      .ret_i     (ret_vec[g]),
      .en_set_i  (en_set[g]),
      .en_clr_i  (en_clr[g]),
      .pend_set_i(pend_set[g]),
      .pend_clr_i(pend_clr[g]),
      .en_o      (en_o[g]),
      .pend_o    (pend_o[g]),
      .act_o     (act_o[g])
    );
  end

  assign cand_o     = pend_o & en_o & ~act_o;
  assign cand_any_o = |cand_o;
endmodule

// File: rtl/irq_trk_checker.sv
module irq_trk_checker #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ID_W      = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] req_i,
  input logic                 wr_valid_i,
  input logic [2:0]           wr_op_i,
  input logic                 enter_i,
  input logic [ID_W-1:0]      enter_id_i,
  input logic                 ret_i,
  input logic [ID_W-1:0]      ret_id_i,
  input logic [NUM_LINES-1:0] en_o,
  input logic [NUM_LINES-1:0] pend_o,
  input logic [NUM_LINES-1:0] act_o
);
  logic [NUM_LINES-1:0] ent_mask, lvl_hit;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) ent_mask[i] = enter_i && (32'(enter_id_i) == i);
  end
  assign lvl_hit = req_i & ~act_o & ~ent_mask;

  a_r2_req_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_hit) |=> ((pend_o & $past(lvl_hit)) == $past(lvl_hit)));

  a_r3_enter_sets_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> act_o[$past(enter_id_i)]);

  a_r5_ret_clears_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !(enter_i && enter_id_i == ret_id_i)) |=> !act_o[$past(ret_id_i)]);

  a_r6_enable_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(en_o));

  a_r9_clear_loses_to_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_op_i == 3'd3 && (|lvl_hit)) |=> ((pend_o & $past(lvl_hit)) == $past(lvl_hit)));
endmodule

bind irq_state_tracker irq_trk_checker #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .wr_valid_i(wr_valid_i),
  .wr_op_i   (wr_op_i),
  .enter_i   (enter_i),
  .enter_id_i(enter_id_i),
  .ret_i     (ret_i),
  .ret_id_i  (ret_id_i),
  .en_o      (en_o),
  .pend_o    (pend_o),
  .act_o     (act_o)
);

// File: tb/tb_irq_state_tracker.sv
module tb_irq_state_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         wr_valid_i = 1'b0;
  logic [2:0]   wr_op_i = '0;
  logic [N-1:0] wr_data_i = '0;
  logic         enter_i = 1'b0;
  logic [2:0]   enter_id_i = '0;
  logic         ret_i = 1'b0;
  logic [2:0]   ret_id_i = '0;
  logic [N-1:0] en_o, pend_o, act_o, cand_o;
  logic         cand_any_o;

  int n_chk = 0;
  int n_bad = 0;

  irq_state_tracker #(.NUM_LINES(N)) dut (
    .clk_i, .rst_ni, .req_i, .wr_valid_i, .wr_op_i, .wr_data_i,
    .enter_i, .enter_id_i, .ret_i, .ret_id_i,
    .en_o, .pend_o, .act_o, .cand_o, .cand_any_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(logic [2:0] op, logic [N-1:0] d);
    wr_valid_i = 1'b1; wr_op_i = op; wr_data_i = d;
    step();
    wr_valid_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic enter(logic [2:0] id);
    enter_i = 1'b1; enter_id_i = id;
    step();
    enter_i = 1'b0;
  endtask

  task automatic leave(logic [2:0] id);
    ret_i = 1'b1; ret_id_i = id;
    step();
    ret_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 en", en_o, '0);
    chk("R1 pend", pend_o, '0);
    chk("R1 act", act_o, '0);
    chk("R1 cand", cand_o, '0);
    chk("R1 any", {7'd0, cand_any_o}, '0);
  endtask

  task automatic t_level();
    wr(3'd0, 8'h04);
    chk("R7 set_en", en_o, 8'h04);
    req_i[2] = 1'b1; step();
    chk("R2 level pend", pend_o, 8'h04);
    chk("R10 cand", cand_o, 8'h04);
    enter(3'd2);
    chk("R3 act", act_o, 8'h04);
    chk("R3 pend cleared", pend_o, 8'h00);
    chk("R10 cand when active", cand_o, 8'h00);
    step(); step();
    chk("R4 held no repend", pend_o, 8'h00);
    leave(3'd2);
    chk("R5 act cleared", act_o, 8'h00);
    chk("R5 held repends", pend_o, 8'h04);
    req_i[2] = 1'b0;
    wr(3'd3, 8'h04);
    chk("R7 clr_pend", pend_o, 8'h00);
  endtask

  task automatic t_pulse();
    req_i[5] = 1'b1; step(); req_i[5] = 1'b0;
    chk("R2 pulse pend", pend_o, 8'h20);
    chk("R6 disabled not cand", cand_o, 8'h00);
    step(); step(); step();
    chk("R6 stays pending", pend_o, 8'h20);
    wr(3'd0, 8'h20);
    chk("R6 cand after enable", cand_o, 8'h20);
    chk("R10 any", {7'd0, cand_any_o}, 8'h01);
    enter(3'd5);
    chk("R3 pulse enter pend", pend_o, 8'h00);
    req_i[5] = 1'b1; step(); req_i[5] = 1'b0;
    chk("R4 edge repends", pend_o, 8'h20);
    chk("R10 active masked", cand_o, 8'h00);
    leave(3'd5);
    chk("R5 low ret act", act_o, 8'h00);
    chk("R5 low ret pend kept", pend_o, 8'h20);
    chk("R10 cand after ret", cand_o, 8'h20);
    wr(3'd3, 8'h20);
    chk("R10 any low", {7'd0, cand_any_o}, 8'h00);
  endtask

  task automatic t_zero_bits();
    wr(3'd0, 8'h00);
    chk("R7 set_en zero", en_o, 8'h24);
    wr(3'd1, 8'h00);
    chk("R7 clr_en zero", en_o, 8'h24);
    wr(3'd1, 8'h04);
    chk("R7 clr_en", en_o, 8'h20);
    wr(3'd2, 8'h00);
    chk("R7 set_pend zero", pend_o, 8'h00);
  endtask

  task automatic t_trig();
    wr(3'd4, 8'd3);
    chk("R8 trig 3", pend_o, 8'h08);
    wr(3'd4, 8'd9);
    chk("R8 trig out of range", pend_o, 8'h08);
    wr(3'd6, 8'hFF);
    chk("R8 unused op", pend_o, 8'h08);
    wr(3'd2, 8'h81);
    chk("R8 set_pend", pend_o, 8'h89);
    wr(3'd3, 8'hFF);
    chk("R8 clear all", pend_o, 8'h00);
  endtask

  task automatic t_race();
    req_i[1] = 1'b1; step();
    wr(3'd3, 8'h02);
    chk("R9 held beats clear", pend_o, 8'h02);
    wr(3'd2, 8'h40);
    req_i[6] = 1'b1;
    wr(3'd3, 8'h40);
    chk("R9 edge beats clear", pend_o, 8'h42);
    req_i = '0;
    wr(3'd3, 8'hFF);
    chk("R9 clear after drop", pend_o, 8'h00);
  endtask

  initial begin
    repeat (2) step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_level();
    t_pulse();
    t_zero_bits();
    t_trig();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule